// File: doc/BRIEF.md
# Eight-Entry Synchronous FIFO with Wrapping Level Field

This block is a single-clock first-in first-out buffer of 9-bit words, eight entries deep, meant to sit on either the transmit or the receive side of a serial controller. Software or a neighbouring state machine reads its occupancy through a 3-bit level field plus three flags: empty, full and half-full. The level field is one bit too narrow to show eight. When the buffer is full it wraps to zero, so a reader must consult the full flag to tell a full buffer from an empty one.

The read side is first-word-fall-through: the oldest stored word is always on the data output while the buffer holds anything, and a read strobe simply retires it. A synchronous flush empties the buffer in one cycle. This is how the enclosing controller drains its receive path before a soft reset. Writes into a full buffer and reads from an empty one are dropped without disturbing stored data or ordering.

Top module: `lvl_fifo`

## Requirements
- R1: After reset, empty is 1, full is 0, half_full is 0 and level is 0.
- R2: A write when not full stores the word, and the occupancy rises by one; for occupancies 0 to 7, level equals the occupancy.
- R3: With 8 entries stored, full is 1, empty is 0 and level reads 0.
- R4: A write while full is ignored: occupancy stays 8 and the stored words and their order are unchanged.
- R5: A read while empty is ignored: the buffer stays empty, and later writes and reads return data in order.
- R6: While not empty, rd_data shows the oldest stored word without a read strobe; each accepted read retires exactly that word.
- R7: half_full is 1 exactly when the occupancy is 4 or more.
- R8: A write and a read in the same cycle, with the buffer neither empty nor full, leave the occupancy unchanged and preserve first-in first-out order.
- R9: flush empties the buffer in one cycle and takes priority over a write or read in the same cycle.
- R10: With both strobes while full, the read is accepted and the write is dropped (occupancy 7). With both strobes while empty, the write is accepted and the read is dropped (occupancy 1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous clear of all contents |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 9 | Word to store |
| rd_en | input | 1 | Read strobe; retires the word on rd_data |
| rd_data | output | 9 | Oldest stored word (valid while not empty) |
| level | output | 3 | Occupancy modulo 8 |
| empty | output | 1 | No words stored |
| full | output | 1 | Eight words stored |
| half_full | output | 1 | Four or more words stored |

## Verification
The buffer is first filled one word at a time past capacity and then drained past empty. This sweep walks every occupancy from 0 to 8 and separates the wrapped level of a full buffer from a truly empty one. Targeted cycles apply both strobes at once when the buffer is empty, partly filled and full, which tells the accept-read-drop-write rule apart from the alternatives. Flush is applied together with both strobes. A long pseudo-random mix of writes, reads and rare flushes is then compared word for word against a queue model, which exposes pointer wrap and ordering faults that short patterns miss.

// File: rtl/lvl_fifo_pkg.sv
package lvl_fifo_pkg;
  typedef struct packed {
    logic empty;
    logic full;
    logic half;
  } lvlf_flags_t;

  function automatic int unsigned half_mark(int unsigned depth);
    return depth / 2;
  endfunction
endpackage

// File: rtl/lvl_fifo_ctrl.sv
module lvl_fifo_ctrl #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic             full,
  input  logic             empty,
  output logic             push,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [CNT_W-1:0] count
);
  logic pop;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return p + PTR_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] c,
                                                   input logic up, input logic dn);
    logic [CNT_W-1:0] r;
    r = c;
    if (up && !dn) r = c + CNT_W'(1);
    else if (dn && !up) r = c - CNT_W'(1);
    return r;
  endfunction

  assign push = wr_en && !full && !flush;
  assign pop  = rd_en && !empty && !flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      count <= next_count(count, push, pop);
    end
  end

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en && !flush) |=> ($stable(wr_ptr) && count <= $past(count)));
  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_en && !flush) |=> $stable(rd_ptr));
  assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0 && wr_ptr == rd_ptr));
  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> count == $past(count) + CNT_W'(1));
  assert_balanced_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> $stable(count));
endmodule

// File: rtl/lvl_fifo_store.sv
module lvl_fifo_store #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned DATA_W = 9,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              push,
  input  logic [PTR_W-1:0]  wr_ptr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PTR_W-1:0]  rd_ptr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] cells [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    always_ff @(posedge clk) begin
      if (push && wr_ptr == PTR_W'(i)) cells[i] <= wr_data;
    end
  end

  assign rd_data = cells[rd_ptr];
endmodule

// File: rtl/lvl_fifo_flags.sv
module lvl_fifo_flags
  import lvl_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  output logic [PTR_W-1:0] level,
  output lvlf_flags_t      flags
);
  localparam int unsigned HALF = half_mark(DEPTH);

  assign level       = count[PTR_W-1:0];
  assign flags.empty = (count == '0);
  assign flags.full  = (count == CNT_W'(DEPTH));
  assign flags.half  = (count >= CNT_W'(HALF));

  assert_full_wraps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    flags.full |-> (level == '0 && !flags.empty && flags.half));
  assert_half_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags.half) |-> (level == PTR_W'(HALF) && $past(flags.empty) == 1'b0 || HALF <= 1));
endmodule

// File: rtl/lvl_fifo.sv
module lvl_fifo
  import lvl_fifo_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned DATA_W = 9,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [PTR_W-1:0]  level,
  output logic              empty,
  output logic              full,
  output logic              half_full
);
  logic             push;
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;
  logic [CNT_W-1:0] count;
  lvlf_flags_t      flags;

  lvl_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en), .rd_en(rd_en),
    .full(flags.full), .empty(flags.empty), .push(push),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .count(count)
  );

  lvl_fifo_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk(clk), .push(push), .wr_ptr(wr_ptr), .wr_data(wr_data),
    .rd_ptr(rd_ptr), .rd_data(rd_data)
  );

  lvl_fifo_flags #(.DEPTH(DEPTH)) u_flags (
    .clk(clk), .rst_n(rst_n), .count(count), .level(level), .flags(flags)
  );

  assign empty     = flags.empty;
  assign full      = flags.full;
  assign half_full = flags.half;

  assert_fwft_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty && !rd_en && !flush) |=> $stable(rd_data));
endmodule

// File: tb/tb_lvl_fifo.sv
module tb_lvl_fifo;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       flush = 1'b0;
  logic       wr_en = 1'b0;
  logic [8:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [8:0] rd_data;
  logic [2:0] level;
  logic       empty, full, half_full;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  int q[$];
  int unsigned seed = 32'h1234_5678;

  lvl_fifo dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .level(level), .empty(empty),
    .full(full), .half_full(half_full)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_state(input string req);
    int n;
    n = q.size();
    chk(req, "empty", int'(empty), int'(n == 0));
    chk(req, "full", int'(full), int'(n == 8));
    chk(req, "half_full", int'(half_full), int'(n >= 4));
    chk(req, "level", int'(level), n % 8);
    if (n > 0) chk(req, "rd_data", int'(rd_data), q[0]);
  endtask

  task automatic step(input bit w, input int d, input bit r, input bit f);
    bit dopush, dopop;
    wr_en = w; wr_data = d[8:0]; rd_en = r; flush = f;
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; rd_en = 0; flush = 0;
    if (f) q.delete();
    else begin
      dopush = w && q.size() < 8;
      dopop  = r && q.size() > 0;
      if (dopop) void'(q.pop_front());
      if (dopush) q.push_back(d & 9'h1FF);
    end
  endtask

  function automatic int unsigned lcg();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed >> 8;
  endfunction

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int sz;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_state("R1");

    // R2 R3 R7: fill one at a time beyond capacity; R4 extra writes dropped
    for (int i = 0; i < 11; i++) begin
      step(1, 9'h100 + i * 37, 0, 0);
      chk_state(i < 8 ? "R2" : "R4");
      if (i == 7) begin
        chk("R3", "level wraps", int'(level), 0);
        chk("R3", "full", int'(full), 1);
      end
      if (i == 2 || i == 3) chk("R7", "half edge", int'(half_full), int'(i == 3));
    end
    // R10: both strobes when full
    step(1, 9'h055, 1, 0);
    chk_state("R10");
    chk("R10", "level after full rd+wr", int'(level), 7);
    // R6: hold without strobe
    sz = int'(rd_data);
    step(0, 0, 0, 0);
    chk("R6", "rd_data held", int'(rd_data), sz);
    // drain past empty: R6 and R5
    for (int i = 0; i < 10; i++) begin
      step(0, 0, 1, 0);
      chk_state(i < 7 ? "R6" : "R5");
    end
    // R10: both strobes when empty
    step(1, 9'h0A5, 1, 0);
    chk_state("R10");
    chk("R10", "level after empty rd+wr", int'(level), 1);
    // R8: balanced traffic at partial fill
    step(1, 9'h011, 0, 0);
    for (int i = 0; i < 6; i++) begin
      step(1, 9'h1C0 + i, 1, 0);
      chk_state("R8");
      chk("R8", "level stable", int'(level), 2);
    end
    // R9: flush with both strobes
    step(1, 9'h022, 0, 0);
    step(1, 9'h033, 1, 1);
    chk_state("R9");
    chk("R9", "empty after flush", int'(empty), 1);
    step(1, 9'h044, 0, 0);
    chk_state("R5");
    // mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      int unsigned v;
      v = lcg();
      step(v[0] | v[1], int'(v[20:12]), v[2] & (v[3] | v[4]), (v[11:5] == 0));
      chk_state("R8");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule